// File: doc/BRIEF.md
# Half-Bridge Gate Command Conditioner

This block sits between the modulator and the two gate stages of one inverter leg. It takes a raw on/off command for the upper switch and one for the lower switch. It then produces two gate enables that cannot both be on. Each turn-on waits for a fixed blanking interval after the leg has gone fully off. Command pulses too short to be real switching intent are treated as noise and dropped.

Three fault indications arrive as digital flags: desaturation of the upper switch, desaturation of the lower switch, and a low gate supply. Any of them sets a latch. The latch kills both gates at once and pulls the health output low. While the latch is set, the commands have no effect on the gates. The latch lets go only when three things hold together: the fault flags are clear, and both commands have stayed low without a break for a fixed release interval.

All intervals are given in nanoseconds and turned into clock cycles from the clock frequency parameter. With the default 50 MHz clock they come out as follows:

- noise filter: 25 cycles
- blanking interval: 190 cycles
- release interval: 450 cycles

Top module: `hbg_leg_ctrl`

## Requirements
- R1: `gate_hi` and `gate_lo` are never high in the same cycle.
- R2: While both commands are high together, neither gate turns on.
- R3: A gate turns on only after both gates have been off for the blanking interval. At the defaults this is 190 cycles (3.8 us), and it must always lie within 3.3 to 4.3 us.
- R4: A command pulse shorter than 25 cycles (500 ns) causes no gate transition.
- R5: A command pulse of 25 cycles or longer reaches its gate, and the gate's on-width matches the pulse width within one cycle. This holds at a 50 kHz toggle rate. From an idle leg, the gate rises 25 to 40 cycles after the command.
- R6: Any of `desat_hi`, `desat_lo` or `uvlo` going high sets the fault latch. Both gates are then off and `healthy` is low within 30 cycles (0.6 us).
- R7: While the latch is set, command pulses produce no gate turn-on.
- R8: The latch clears only after both commands have been low continuously for 450 cycles (9 us). Any high command restarts that count. `healthy` returns high 450 to 470 cycles after the last command goes low.
- R9: While a fault flag is still high, the latch stays set no matter how long the commands stay low. The release count starts only once the flag drops.
- R10: After reset, both gates are off and `healthy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_hi | input | 1 | Raw on-command for the upper switch |
| cmd_lo | input | 1 | Raw on-command for the lower switch |
| desat_hi | input | 1 | Desaturation flag of the upper switch |
| desat_lo | input | 1 | Desaturation flag of the lower switch |
| uvlo | input | 1 | Gate supply below threshold |
| gate_hi | output | 1 | Gate enable, upper switch |
| gate_lo | output | 1 | Gate enable, lower switch |
| healthy | output | 1 | High when no fault is latched |

## Verification
The bench probes the filter threshold with random pulse lengths on both sides of 25 cycles. A filter that is off by one would pass a 24-cycle glitch or eat a legal 25-cycle pulse.

It swaps the leg directly from upper to lower and measures the off gap. A missing or short blanking interval would show as a gap of a few cycles, or as overlap.

It drives both commands high at once, which a naive priority scheme would turn into a single gate turning on.

For the fault latch, it breaks the release interval with a short command pulse and holds the supply flag high with the commands low. A latch that ignores the restart or the live fault would report healthy too early.

// File: rtl/hbg_pkg.sv
// Package: shared types and cycle conversion for the half-bridge gate conditioner.
// Assumes: integer nanosecond inputs; rounding is upward so no interval shrinks.
package hbg_pkg;

    // Raw pin bundle carried through the synchronizer as one vector.
    typedef struct packed {
        logic desat_hi;
        logic desat_lo;
        logic uvlo;
        logic cmd_hi;
        logic cmd_lo;
    } leg_in_t;

    // Convert a duration in ns into whole clock cycles, rounding up.
    function automatic logic [31:0] ns_to_cyc(input longint unsigned clk_hz,
                                              input longint unsigned ns);
        return 32'((clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

endpackage

// File: rtl/hbg_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous flags.
// Assumes: each bit is independent (no multi-bit coherence is needed);
// STAGES >= 2. The reset value is all zero.
module hbg_sync #(
    parameter int unsigned W      = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/hbg_glitch_filter.sv
// Module: noise filter for one synchronized command bit.
// The output takes a new level only after the input has held that level
// for FILT_CYC consecutive samples. Shorter excursions are dropped, and
// accepted pulses keep their width.
// Assumes: FILT_CYC >= 1; the input is already synchronous.
module hbg_glitch_filter #(
    parameter int unsigned FILT_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int unsigned CW = $clog2(FILT_CYC + 1);

    logic [CW-1:0] run_cnt;

    // Count samples that disagree with the output; flip once enough agree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean   <= 1'b0;
            run_cnt <= '0;
        end else if (raw == clean) begin
            run_cnt <= '0;
        end else if (run_cnt == CW'(FILT_CYC - 1)) begin
            clean   <= raw;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R4: the output may only move toward the level the input held last sample.
    a_r4_flip_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        (clean != $past(clean)) |-> (clean == $past(raw)));

endmodule

// File: rtl/hbg_fault_latch.sv
// Module: fault latch with a timed release.
// Any fault source sets the latch. The latch releases once the fault source
// is low and both commands have stayed low for CLR_CYC consecutive cycles;
// any high command restarts the count.
// Assumes: inputs are synchronous; CLR_CYC >= 2.
module hbg_fault_latch #(
    parameter int unsigned CLR_CYC = 450
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_src,
    input  logic cmd_any,
    output logic latched
);
    localparam int unsigned CW = $clog2(CLR_CYC + 1);

    logic [CW-1:0] quiet_cnt;

    // Set on any fault; time the quiet interval while latched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latched   <= 1'b0;
            quiet_cnt <= '0;
        end else if (fault_src) begin
            latched   <= 1'b1;
            quiet_cnt <= '0;
        end else if (latched) begin
            if (cmd_any) begin
                quiet_cnt <= '0;
            end else if (quiet_cnt == CW'(CLR_CYC - 1)) begin
                latched   <= 1'b0;
                quiet_cnt <= '0;
            end else begin
                quiet_cnt <= quiet_cnt + 1'b1;
            end
        end else begin
            quiet_cnt <= '0;
        end
    end

    // R6: a fault source is latched on the next cycle.
    a_r6_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fault_src |=> latched);

    // R9: a live fault never lets the latch go.
    a_r9_live_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && fault_src) |=> latched);

    // R8: a high command during the latch prevents release.
    a_r8_cmd_blocks_release: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && cmd_any) |=> latched);

endmodule

// File: rtl/hbg_deadtime.sv
// Module: leg interlock and turn-on blanking.
// A side is wanted only when its request is alone. An on gate drops at once
// when it stops being wanted. A gate may turn on only after both gates have
// been off for DEAD_CYC cycles.
// Assumes: DEAD_CYC >= 2; requests are synchronous and already filtered.
module hbg_deadtime #(
    parameter int unsigned DEAD_CYC = 190
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_hi,
    input  logic req_lo,
    output logic gate_hi,
    output logic gate_lo
);
    localparam int unsigned CW        = $clog2(DEAD_CYC + 1);
    localparam int unsigned DEAD_LAST = DEAD_CYC - 1;

    logic          want_hi;
    logic          want_lo;
    logic [CW-1:0] off_cnt;

    // A side is wanted only when its request is exclusive.
    always_comb begin
        want_hi = req_hi & ~req_lo;
        want_lo = req_lo & ~req_hi;
    end

    // Drop gates immediately; grant turn-on after the blanking count expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
            off_cnt <= '0;
        end else if ((gate_hi && !want_hi) || (gate_lo && !want_lo)) begin
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
            off_cnt <= '0;
        end else if (!gate_hi && !gate_lo) begin
            if (off_cnt != CW'(DEAD_LAST)) begin
                off_cnt <= off_cnt + 1'b1;
            end else if (want_hi) begin
                gate_hi <= 1'b1;
            end else if (want_lo) begin
                gate_lo <= 1'b1;
            end
        end
    end

    // Check-only counter: cycles both gates have been observed off.
    logic [CW-1:0] chk_off_run;
    always_ff @(posedge clk) begin
        if (!rst_n)                         chk_off_run <= '0;
        else if (gate_hi || gate_lo)        chk_off_run <= '0;
        else if (chk_off_run != CW'(DEAD_CYC)) chk_off_run <= chk_off_run + 1'b1;
    end

    // R1: never both gates on.
    a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    // R2: a double request leaves both gates off next cycle.
    a_r2_double_req_off: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hi && req_lo) |=> (!gate_hi && !gate_lo));

    // R3: every turn-on follows a full blanking interval.
    a_r3_blank_before_on: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_hi) || $rose(gate_lo)) |-> (chk_off_run >= CW'(DEAD_CYC - 1)));

endmodule

// File: rtl/hbg_leg_ctrl.sv
// Module: top of the half-bridge gate command conditioner.
// Chain: synchronizer -> per-command noise filter -> fault mask -> interlock
// and blanking. The fault latch is fed from the synchronized flags, and its
// release timer watches the synchronized (unfiltered) commands.
// Assumes: all inputs asynchronous to clk; timing parameters in ns.
module hbg_leg_ctrl #(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned GLITCH_NS   = 500,
    parameter int unsigned DEAD_NS     = 3800,
    parameter int unsigned CLEAR_NS    = 9000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_hi,
    input  logic cmd_lo,
    input  logic desat_hi,
    input  logic desat_lo,
    input  logic uvlo,
    output logic gate_hi,
    output logic gate_lo,
    output logic healthy
);
    import hbg_pkg::*;

    localparam int unsigned FILT_CYC = ns_to_cyc(CLK_HZ, GLITCH_NS);
    localparam int unsigned DEAD_CYC = ns_to_cyc(CLK_HZ, DEAD_NS);
    localparam int unsigned CLR_CYC  = ns_to_cyc(CLK_HZ, CLEAR_NS);
    localparam int unsigned IN_W     = $bits(leg_in_t);
    localparam int unsigned N_CMD    = 2;

    leg_in_t           pins_raw;
    leg_in_t           pins_s;
    logic [N_CMD-1:0]  cmd_s;
    logic [N_CMD-1:0]  cmd_clean;
    logic [N_CMD-1:0]  req;
    logic              fault_src;
    logic              cmd_any;
    logic              latched;

    // Gather the raw pins into one bundle for synchronization.
    always_comb begin
        pins_raw.desat_hi = desat_hi;
        pins_raw.desat_lo = desat_lo;
        pins_raw.uvlo     = uvlo;
        pins_raw.cmd_hi   = cmd_hi;
        pins_raw.cmd_lo   = cmd_lo;
    end

    hbg_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    assign cmd_s = {pins_s.cmd_hi, pins_s.cmd_lo};

    // One noise filter per command bit.
    for (genvar g = 0; g < N_CMD; g++) begin : g_filt
        hbg_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (cmd_s[g]),
            .clean (cmd_clean[g])
        );
    end

    // Fault sources and release-timer input.
    always_comb begin
        fault_src = pins_s.desat_hi | pins_s.desat_lo | pins_s.uvlo;
        cmd_any   = |cmd_s;
        req       = cmd_clean & {N_CMD{~latched}};
    end

    hbg_fault_latch #(.CLR_CYC(CLR_CYC)) u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_src (fault_src),
        .cmd_any   (cmd_any),
        .latched   (latched)
    );

    hbg_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dead (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_hi  (req[1]),
        .req_lo  (req[0]),
        .gate_hi (gate_hi),
        .gate_lo (gate_lo)
    );

    assign healthy = ~latched;

    // R6, R7: a set latch leaves both gates off from the next cycle on.
    a_r6_latch_kills_gates: assert property (@(posedge clk) disable iff (!rst_n)
        latched |=> (!gate_hi && !gate_lo));

    // R10: reset leaves the leg off and healthy.
    a_r10_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!gate_hi && !gate_lo && healthy));

endmodule

// File: tb/hbg_leg_ctrl_bench.sv
module hbg_leg_ctrl_bench;
    localparam int FILT = 25;
    localparam int DEAD = 190;
    localparam int CLR  = 450;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_hi = 1'b0, cmd_lo = 1'b0;
    logic desat_hi = 1'b0, desat_lo = 1'b0, uvlo = 1'b0;
    logic gate_hi, gate_lo, healthy;

    int total = 0, fails = 0;
    bit finished = 1'b0;
    int overlap_err = 0, fault_err = 0, flt_age = 0;
    int rise_hi = 0, rise_lo = 0, hi_cycles = 0;
    logic prev_hi = 1'b0, prev_lo = 1'b0;

    hbg_leg_ctrl u_hbg_leg_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
        .desat_hi(desat_hi), .desat_lo(desat_lo), .uvlo(uvlo),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .healthy(healthy)
    );

    always #10 clk = ~clk;

    // Expected filter outcome for a pulse of the given length.
    function automatic bit pulse_should_pass(input int len);
        return len >= FILT;
    endfunction

    // Blanking window limits in cycles from the 3.3 to 4.3 us rule at 20 ns.
    function automatic bit gap_ok(input int n);
        return (n >= 165) && (n <= 215);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_mon();
        rise_hi = 0; rise_lo = 0; hi_cycles = 0;
    endtask

    // Continuous monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (gate_hi && gate_lo) overlap_err++;
            if (desat_hi || desat_lo || uvlo) flt_age++; else flt_age = 0;
            if (flt_age >= 6 && (gate_hi || gate_lo)) fault_err++;
            if (gate_hi && !prev_hi) rise_hi++;
            if (gate_lo && !prev_lo) rise_lo++;
            if (gate_hi) hi_cycles++;
        end
        prev_hi = gate_hi;
        prev_lo = gate_lo;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", 150000, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int n;
        int len;
        bit exp_pass;
        bit saw;
        void'($urandom(32'd20240611));
        cyc(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(gate_hi == 1'b0, "R10 gate_hi after reset", gate_hi, 0);
        chk(gate_lo == 1'b0, "R10 gate_lo after reset", gate_lo, 0);
        chk(healthy == 1'b1, "R10 healthy after reset", healthy, 1);
        cyc(300);

        // R5 turn-on latency and width from idle
        clr_mon();
        cmd_hi = 1'b1;
        n = 0;
        while (!gate_hi && n < 100) begin @(negedge clk); n++; end
        chk(n >= 25 && n <= 40, "R5 rise delay", n, 28);
        cyc(400 - n);
        cmd_hi = 1'b0;
        cyc(100);
        chk(hi_cycles >= 399 && hi_cycles <= 401, "R5 on-width", hi_cycles, 400);
        cyc(300);

        // R4 short glitches on both commands
        clr_mon();
        cmd_hi = 1'b1; cyc(24); cmd_hi = 1'b0;
        cyc(50);
        cmd_lo = 1'b1; cyc(10); cmd_lo = 1'b0;
        cyc(100);
        chk(rise_hi == 0, "R4 24-cycle pulse on hi suppressed", rise_hi, 0);
        chk(rise_lo == 0, "R4 10-cycle pulse on lo suppressed", rise_lo, 0);

        // R3 blanking on direct swap
        cmd_hi = 1'b1; cyc(300);
        cmd_hi = 1'b0; cmd_lo = 1'b1;
        while (gate_hi) @(negedge clk);
        n = 0;
        while (!gate_lo && n < 400) begin n++; @(negedge clk); end
        chk(gap_ok(n), "R3 hi-to-lo gap", n, DEAD);
        cyc(200);
        cmd_lo = 1'b0; cmd_hi = 1'b1;
        while (gate_lo) @(negedge clk);
        n = 0;
        while (!gate_hi && n < 400) begin n++; @(negedge clk); end
        chk(gap_ok(n), "R3 lo-to-hi gap", n, DEAD);
        cyc(100);
        cmd_hi = 1'b0;
        cyc(300);

        // R2 both commands at once
        clr_mon();
        cmd_hi = 1'b1; cmd_lo = 1'b1;
        cyc(400);
        cmd_hi = 1'b0; cmd_lo = 1'b0;
        cyc(50);
        chk(rise_hi + rise_lo == 0, "R2 double command", rise_hi + rise_lo, 0);
        cyc(300);

        // R5 50 kHz toggling
        clr_mon();
        for (int k = 0; k < 3; k++) begin
            cmd_hi = 1'b1; cyc(500);
            cmd_hi = 1'b0; cyc(500);
        end
        chk(rise_hi == 3, "R5 rises at 50 kHz", rise_hi, 3);
        chk(hi_cycles >= 1497 && hi_cycles <= 1503, "R5 total on time at 50 kHz", hi_cycles, 1500);
        cyc(300);

        // R4/R5 random pulse lengths around the threshold
        for (int t = 0; t < 16; t++) begin
            len = $urandom_range(12, 40);
            exp_pass = pulse_should_pass(len);
            clr_mon();
            cmd_hi = 1'b1; cyc(len); cmd_hi = 1'b0;
            cyc(100);
            saw = (rise_hi != 0);
            chk(saw == exp_pass, $sformatf("R4 R5 pulse len %0d pass", len), saw, exp_pass);
            if (exp_pass)
                chk(hi_cycles >= len - 1 && hi_cycles <= len + 1, "R5 random width", hi_cycles, len);
            cyc(300);
        end

        // R6 desaturation on the upper switch
        cmd_hi = 1'b1;
        while (!gate_hi) @(negedge clk);
        cyc(20);
        desat_hi = 1'b1;
        n = 0;
        while ((gate_hi || healthy) && n < 100) begin @(negedge clk); n++; end
        chk(n >= 1 && n <= 30, "R6 upper desat response", n, 4);
        cyc(20);
        desat_hi = 1'b0;
        // R7 command held during latch
        clr_mon();
        cyc(200);
        chk(rise_hi == 0, "R7 command ignored while latched", rise_hi, 0);
        chk(healthy == 1'b0, "R7 latch held with command high", healthy, 0);
        cmd_hi = 1'b0;
        cyc(300);
        chk(healthy == 1'b0, "R8 not released after 300 quiet", healthy, 0);
        clr_mon();
        cmd_hi = 1'b1; cyc(30); cmd_hi = 1'b0;
        cyc(440);
        chk(healthy == 1'b0, "R8 restart after pulse", healthy, 0);
        chk(rise_hi == 0, "R7 pulse ignored while latched", rise_hi, 0);
        n = 440;
        while (!healthy && n < 700) begin @(negedge clk); n++; end
        chk(n >= CLR && n <= 470, "R8 release timing", n, CLR);
        cyc(300);

        // R6 desaturation on the lower switch
        cmd_lo = 1'b1;
        while (!gate_lo) @(negedge clk);
        desat_lo = 1'b1;
        n = 0;
        while ((gate_lo || healthy) && n < 100) begin @(negedge clk); n++; end
        chk(n >= 1 && n <= 30, "R6 lower desat response", n, 4);
        cyc(10);
        desat_lo = 1'b0;
        cmd_lo = 1'b0;
        cyc(600);
        chk(healthy == 1'b1, "R8 released after quiet", healthy, 1);

        // R9 undervoltage held with commands low
        uvlo = 1'b1;
        cyc(1000);
        chk(healthy == 1'b0, "R9 live undervoltage keeps latch", healthy, 0);
        uvlo = 1'b0;
        n = 0;
        while (!healthy && n < 700) begin @(negedge clk); n++; end
        chk(n >= CLR && n <= 470, "R9 release after flag drops", n, CLR);
        cyc(300);

        // R1/R6 random stress
        for (int s = 0; s < 40; s++) begin
            logic [1:0] c;
            c = 2'($urandom_range(0, 3));
            cmd_hi = c[1]; cmd_lo = c[0];
            if ($urandom_range(0, 7) == 0) begin
                case ($urandom_range(0, 2))
                    0: desat_hi = 1'b1;
                    1: desat_lo = 1'b1;
                    default: uvlo = 1'b1;
                endcase
                cyc($urandom_range(1, 20));
                desat_hi = 1'b0; desat_lo = 1'b0; uvlo = 1'b0;
            end
            cyc($urandom_range(1, 400));
        end
        cmd_hi = 1'b0; cmd_lo = 1'b0;
        cyc(700);
        chk(healthy == 1'b1, "R8 healthy after stress", healthy, 1);
        chk(overlap_err == 0, "R1 no overlap over whole run", overlap_err, 0);
        chk(fault_err == 0, "R6 gates off during faults", fault_err, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule